// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from up to eight peripheral lines and one non-maskable line. It presents a single request and a vector address to a processor core. Each source has a sticky pending flag inside the controller. A flag is set by a request pulse whatever the masking. It is cleared on acknowledge when the source's auto-clear option is on, or by an explicit software clear. A source competes for service only when its flag is set, its own enable is on and the global enable is on. The non-maskable source ignores both enables.

Each maskable source carries a software-writable priority. The eligible source with the highest priority is offered first. The core signals handler entry with an acknowledge and handler exit with an end-of-interrupt. On acknowledge the controller pushes the served level onto a nesting stack. A new request is offered only if its level is strictly above the level on top of that stack. End-of-interrupt pops the stack, so the interrupted handler's level becomes active again.

The vector is a computed table address for the selected source. The table memory and the core sit outside the block.

Top module: `prio_vec_intc`

## Requirements
- R1: A request pulse on a source sets its pending flag, seen on `pend_o` (bit 8 = non-maskable) one cycle later. The flag is set whatever the enables, and it stays set while the source is masked.
- R2: A source whose `src_en_i` bit is 0 is never offered, but other enabled pending sources are still offered. Its flag is kept, and it is offered once re-enabled.
- R3: With `gie_i` low no maskable source is offered, though flags still latch. The non-maskable source is offered with either enable off.
- R4: Among eligible sources the highest priority is offered first. Equal priorities go to the lower source index. The sources not chosen stay pending and are served later.
- R5: While a handler is active, a pending source is offered only if its level is strictly higher than the active level. Equal or lower levels wait.
- R6: End-of-interrupt restores the level that was active before the current handler, which may be another interrupted handler. End-of-interrupt with no active handler has no effect.
- R7: With `autoclr_i[i]` set, acknowledge clears source i's flag. Without it the flag stays, and the same source is offered again once its level allows. `sw_clr_i` clears flags, and the non-maskable flag always clears on acknowledge.
- R8: The vector is VEC_BASE + index*VEC_STRIDE (defaults 0x40 and 4). The non-maskable source uses index 8, giving 0x60.
- R9: Priorities are 3-bit values, and a larger value means a higher priority. After reset source i has priority i. A write through `cfg_we_i` changes the priority of source `cfg_sel_i`. The non-maskable source ranks above every maskable level.
- R10: `cpu_req_o` rises two cycles after a request pulse into an idle controller. It and `cpu_vec_o` stay constant until acknowledge. Acknowledge drops the request in the next cycle and makes the served level active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Peripheral request pulses, one per source |
| nmi_i | input | 1 | Non-maskable request pulse |
| src_en_i | input | 8 | Per-source enable |
| gie_i | input | 1 | Global enable for maskable sources |
| autoclr_i | input | 8 | Per-source clear-on-acknowledge option |
| sw_clr_i | input | 8 | Software clear of pending flags, one per source |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_sel_i | input | 3 | Source whose priority is written |
| cfg_prio_i | input | 3 | Priority value to write |
| pend_o | output | 9 | Pending flags, non-maskable in the top bit |
| cpu_req_o | output | 1 | Interrupt request to the core |
| cpu_vec_o | output | 16 | Vector address of the offered source |
| cpu_ack_i | input | 1 | Handler entry acknowledge |
| cpu_eoi_i | input | 1 | Handler end-of-interrupt |

## Verification
A corrupted nesting stack shows at the ports in one of two ways. A request is withheld that a lower active level should let through. Or a request is raised while an equal level is still active. Both show within two cycles of the end-of-interrupt that exposes the bad entry. A wrong pending flag shows on `pend_o` one cycle after the pulse or acknowledge that should have moved it. A wrong pick between sources shows as a mismatched vector at the next acknowledge. The bench therefore checks every vector at acknowledge, and it checks that requests stay absent at the cycles where nesting or masking must hold them back.

// File: rtl/ivc_pkg.sv
// Shared definitions for the prioritized vectored interrupt controller.
// Assumes: consumers size their own vectors from their parameters.
package ivc_pkg;
    localparam int DEF_NSRC   = 8;
    localparam int DEF_PRIO_W = 3;
    localparam int DEF_VEC_W  = 16;

    // Operation applied to the nesting stack in a given cycle.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/ivc_prio_regs.sv
// Per-source priority registers. After reset source i holds i modulo the level count.
// Assumes: a single write port; sel_i addresses a maskable source.
module ivc_prio_regs #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [$clog2(NSRC)-1:0]       sel_i,
    input  logic [PRIO_W-1:0]             val_i,
    output logic [NSRC-1:0][PRIO_W-1:0]   prio_o
);
    localparam int SEL_W = $clog2(NSRC);
    localparam int LVLS  = 2 ** PRIO_W;

    for (genvar g = 0; g < NSRC; g++) begin : g_reg
        // Hold one source's priority; reset to its default, load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_o[g] <= PRIO_W'(g % LVLS);
            else if (we_i && sel_i == SEL_W'(g))
                prio_o[g] <= val_i;
        end
    end
endmodule

// File: rtl/ivc_pending.sv
// Sticky pending flags. A set beats a clear in the same cycle, so no event is lost.
// Assumes: set and clear vectors are already aligned to the flag order.
module ivc_pending #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // Latch new requests and drop cleared flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= '0;
        else
            pend_o <= (pend_o & ~clr_i) | set_i;
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R1
endmodule

// File: rtl/ivc_arbiter.sv
// Picks the eligible source of highest rank. Ties go to the lower index.
// Rank is priority+1 for maskable sources. The non-maskable source (index NSRC)
// ranks above all. Assumes: elig_i already has the masking applied.
module ivc_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int RW     = 4,
    parameter int IW     = 4
) (
    input  logic [NSRC:0]               elig_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                        valid_o,
    output logic [IW-1:0]               idx_o,
    output logic [RW-1:0]               rank_o
);
    localparam int NMI_RANK = 2 ** PRIO_W + 1;

    // Scan upward, replacing only on a strictly higher rank so the lower index keeps a tie.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        rank_o  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig_i[i] && (!valid_o || (RW'({1'b0, prio_i[i]}) + RW'(1)) > rank_o)) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                rank_o  = RW'({1'b0, prio_i[i]}) + RW'(1);
            end
        end
        if (elig_i[NSRC]) begin
            valid_o = 1'b1;
            idx_o   = IW'(NSRC);
            rank_o  = RW'(NMI_RANK);
        end
    end
endmodule

// File: rtl/ivc_nest_stack.sv
// Stack of active ranks. An empty stack reports rank 0, meaning no handler is running.
// Assumes: pushes carry a rank strictly above the current top, so DEPTH entries suffice.
module ivc_nest_stack #(
    parameter int DEPTH = 9,
    parameter int RW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [RW-1:0] push_rank_i,
    input  logic          pop_i,
    output logic [RW-1:0] top_rank_o
);
    localparam int SPW = $clog2(DEPTH + 1);

    logic [RW-1:0]  stk [DEPTH];
    logic [SPW-1:0] sp;

    // Push on handler entry, pop on handler exit; ignore a pop when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push_i && sp < SPW'(DEPTH)) begin
            stk[sp] <= push_rank_i;
            sp      <= sp + SPW'(1);
        end else if (pop_i && sp != '0) begin
            sp <= sp - SPW'(1);
        end
    end

    // Report the level of the running handler.
    always_comb top_rank_o = (sp == '0) ? '0 : stk[sp - SPW'(1)];

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (push_rank_i > top_rank_o)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (sp < SPW'(DEPTH))); // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && sp == '0) |=> (sp == '0)); // R6
endmodule

// File: rtl/prio_vec_intc.sv
// Prioritized vectored interrupt controller top. It latches pending flags and applies
// per-source and global masks. It offers the best source above the active level, holds
// the request and vector until acknowledge, and tracks nested levels.
// Assumes: ack only while cpu_req_o is high; ack and eoi are not given together.
module prio_vec_intc
    import ivc_pkg::*;
#(
    parameter int NSRC       = DEF_NSRC,
    parameter int PRIO_W     = DEF_PRIO_W,
    parameter int VEC_W      = DEF_VEC_W,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         irq_i,
    input  logic                    nmi_i,
    input  logic [NSRC-1:0]         src_en_i,
    input  logic                    gie_i,
    input  logic [NSRC-1:0]         autoclr_i,
    input  logic [NSRC-1:0]         sw_clr_i,
    input  logic                    cfg_we_i,
    input  logic [$clog2(NSRC)-1:0] cfg_sel_i,
    input  logic [PRIO_W-1:0]       cfg_prio_i,
    output logic [NSRC:0]           pend_o,
    output logic                    cpu_req_o,
    output logic [VEC_W-1:0]        cpu_vec_o,
    input  logic                    cpu_ack_i,
    input  logic                    cpu_eoi_i
);
    localparam int LVLS     = 2 ** PRIO_W;
    localparam int NMI_RANK = LVLS + 1;
    localparam int RW       = $clog2(NMI_RANK + 1);
    localparam int IW       = $clog2(NSRC + 1);
    localparam int DEPTH    = LVLS + 1;

    logic [NSRC-1:0][PRIO_W-1:0] prio;
    logic [NSRC:0]               elig, ack_clr, clr_all;
    logic                        arb_valid, take, ack_fire;
    logic [IW-1:0]               arb_idx, idx_q;
    logic [RW-1:0]               arb_rank, rank_q, active_rank;
    logic [VEC_W-1:0]            vec_next;
    stk_op_e                     stk_op;

    ivc_prio_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
        .val_i(cfg_prio_i), .prio_o(prio));

    ivc_pending #(.N(NSRC + 1)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i({nmi_i, irq_i}), .clr_i(clr_all),
        .pend_o(pend_o));

    // Apply the per-source and global masks; the non-maskable flag passes unmasked.
    always_comb elig = {pend_o[NSRC], pend_o[NSRC-1:0] & src_en_i & {NSRC{gie_i}}};

    ivc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .RW(RW), .IW(IW)) u_arb (
        .elig_i(elig), .prio_i(prio), .valid_o(arb_valid), .idx_o(arb_idx),
        .rank_o(arb_rank));

    ivc_nest_stack #(.DEPTH(DEPTH), .RW(RW)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(stk_op == STK_PUSH), .push_rank_i(rank_q),
        .pop_i(stk_op == STK_POP), .top_rank_o(active_rank));

    // Decide whether to offer a new source and what stack operation this cycle needs.
    always_comb begin
        ack_fire = cpu_req_o && cpu_ack_i;
        take     = !cpu_req_o && arb_valid && (arb_rank > active_rank);
        vec_next = VEC_W'(VEC_BASE) + VEC_W'(arb_idx) * VEC_W'(VEC_STRIDE);
        if (ack_fire)       stk_op = STK_PUSH;
        else if (cpu_eoi_i) stk_op = STK_POP;
        else                stk_op = STK_HOLD;
    end

    // Build the clear-on-acknowledge vector; the non-maskable flag always clears.
    for (genvar g = 0; g < NSRC; g++) begin : g_aclr
        assign ack_clr[g] = ack_fire && (idx_q == IW'(g)) && autoclr_i[g];
    end
    assign ack_clr[NSRC] = ack_fire && (idx_q == IW'(NSRC));
    assign clr_all       = ack_clr | {1'b0, sw_clr_i};

    // Hold the offered request and vector from assertion until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_req_o <= 1'b0;
            cpu_vec_o <= '0;
            idx_q     <= '0;
            rank_q    <= '0;
        end else if (ack_fire) begin
            cpu_req_o <= 1'b0;
        end else if (take) begin
            cpu_req_o <= 1'b1;
            cpu_vec_o <= vec_next;
            idx_q     <= arb_idx;
            rank_q    <= arb_rank;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && !cpu_ack_i) |=> (cpu_req_o && $stable(cpu_vec_o))); // R10
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !cpu_req_o); // R10
    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_req_o) && idx_q != IW'(NSRC)) |-> $past(gie_i)); // R3
endmodule

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected vector before each acknowledge;
// a monitor compares the vector seen at every acknowledge edge.
module tb_prio_vec_intc;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  irq = '0, src_en = 8'hFF, autoclr = 8'hFF, sw_clr = '0;
    logic        nmi = 1'b0, gie = 1'b1, cfg_we = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic [2:0]  cfg_sel = '0, cfg_prio = '0;
    logic [8:0]  pend;
    logic        req;
    logic [15:0] vec;

    int n_chk = 0, n_bad = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    prio_vec_intc dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .src_en_i(src_en),
        .gie_i(gie), .autoclr_i(autoclr), .sw_clr_i(sw_clr), .cfg_we_i(cfg_we),
        .cfg_sel_i(cfg_sel), .cfg_prio_i(cfg_prio), .pend_o(pend), .cpu_req_o(req),
        .cpu_vec_o(vec), .cpu_ack_i(ack), .cpu_eoi_i(eoi));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare the vector at every acknowledge edge against the queue head.
    always @(posedge clk) begin
        if (rst_n && ack && req) begin
            if (exp_q.size() == 0) chk("R8 unexpected ack", int'(vec), -1);
            else chk(tag_q.pop_front(), int'(vec), exp_q.pop_front());
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(logic [7:0] m, logic n);
        @(negedge clk); irq = m; nmi = n;
        @(negedge clk); irq = '0; nmi = 1'b0;
    endtask

    // Driver: queue the expected vector, wait for a request, then acknowledge it.
    task automatic serve(string tag, int exp);
        bit seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = req;
        end
        if (!seen) chk({tag, " request missing"}, 0, 1);
        else begin
            exp_q.push_back(exp); tag_q.push_back(tag);
            ack = 1'b1; @(negedge clk); ack = 1'b0;
        end
    endtask

    task automatic end_isr();
        @(negedge clk); eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    endtask

    task automatic no_req(string tag);
        tick(3); chk(tag, int'(req), 0);
    endtask

    task automatic set_prio(int s, int p);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = 3'(s); cfg_prio = 3'(p);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        #(4 * 50000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3); rst_n = 1'b1; tick(1);
        chk("reset req", int'(req), 0);
        chk("reset pend", int'(pend), 0);
        chk("reset vec", int'(vec), 0);

        // R4 R9 R8: defaults give source 5 over source 2.
        pulse(8'b0010_0100, 1'b0);
        chk("R1 flags latch", int'(pend), 'h24);
        chk("R10 req not yet", int'(req), 0);
        tick(1); chk("R10 req two cycles after pulse", int'(req), 1);
        serve("R4 highest first", 'h54);
        no_req("R5 lower waits while active");
        chk("R4 loser stays pending", int'(pend[2]), 1);
        end_isr();
        serve("R4 loser served after", 'h48);
        end_isr();

        // R4 R9: tie after a priority write goes to lower index.
        set_prio(6, 3);
        pulse(8'b0100_1000, 1'b0);
        serve("R4 tie lower index", 'h4C);
        end_isr();
        serve("R9 tie partner after", 'h58);
        end_isr();

        // R5 R6: nesting.
        pulse(8'b0000_1000, 1'b0);
        serve("R5 first handler", 'h4C);
        pulse(8'b0000_1000, 1'b0);
        no_req("R5 equal level no preempt");
        pulse(8'b0001_0000, 1'b0);
        serve("R5 higher preempts", 'h50);
        no_req("R5 nothing above level 5");
        end_isr();
        no_req("R6 returns to interrupted level");
        end_isr();
        serve("R6 waiting source after return", 'h4C);
        end_isr();

        // R2: per-source disable.
        src_en = 8'hFD;
        pulse(8'b0000_0011, 1'b0);
        serve("R2 enabled source forwarded", 'h40);
        end_isr();
        no_req("R2 disabled source not offered");
        chk("R2 disabled flag kept", int'(pend[1]), 1);
        src_en = 8'hFF;
        serve("R2 offered after re-enable", 'h44);
        end_isr();

        // R3: global enable and non-maskable source.
        gie = 1'b0; src_en = 8'h7F;
        pulse(8'b1000_0000, 1'b0);
        no_req("R3 global off blocks maskable");
        chk("R3 flag latches while off", int'(pend[7]), 1);
        pulse(8'h00, 1'b1);
        serve("R3 R8 nmi bypasses enables", 'h60);
        tick(1); chk("R7 nmi flag cleared on ack", int'(pend[8]), 0);
        end_isr();
        gie = 1'b1; src_en = 8'hFF;
        serve("R3 pending served when enabled", 'h5C);
        end_isr();

        // R7: no auto-clear, then software clear.
        autoclr = 8'hFE;
        pulse(8'b0000_0001, 1'b0);
        serve("R7 first service", 'h40);
        tick(1); chk("R7 flag kept without autoclear", int'(pend[0]), 1);
        end_isr();
        serve("R7 same source again", 'h40);
        @(negedge clk); sw_clr = 8'h01; @(negedge clk); sw_clr = '0;
        chk("R7 software clear", int'(pend[0]), 0);
        end_isr();
        no_req("R7 no service after clear");
        autoclr = 8'hFF;

        // R6: end-of-interrupt on an empty stack is ignored.
        end_isr(); end_isr();
        pulse(8'b0000_0001, 1'b0);
        serve("R6 lowest level still served after empty eoi", 'h40);
        end_isr();

        // R10: held request and vector until acknowledge.
        pulse(8'b0000_0010, 1'b0);
        tick(2);
        pulse(8'b1000_0000, 1'b0);
        tick(4);
        chk("R10 request held", int'(req), 1);
        chk("R10 vector held", int'(vec), 'h44);
        serve("R10 held vector at ack", 'h44);
        serve("R5 higher preempts after ack", 'h5C);
        end_isr(); end_isr();
        no_req("R6 idle after both returns");

        tick(2);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule